// File: doc/BRIEF.md
# General-Purpose I/O Bank with Per-Pin Interrupt Detection

This block serves one bank of general-purpose pins. A register file reached over a plain read/write port holds the bank's state. Software drives each pin's output value and tri-state enable from two of these registers, and reads the pin levels after synchronization from a third. Each incoming pin passes through a two-flop synchronizer. An extra flop keeps the previous sample, so the bank can detect edges as well as levels.

For each pin, two bits set the interrupt mode. The mode bit picks edge (0) or level (1), and the sense bit picks falling/low (0) or rising/high (1). A pin can raise an event only when its route bit is set. Events latch into a status register whether or not they are enabled. Software clears a status bit only by writing a one to the status register's clear address. The bank drives one interrupt line, which is high while any latched status bit is also enabled.

Every register sits at a 16-byte stride. Each register has four word addresses: plain write (+0x0), set (+0x4), clear (+0x8) and toggle (+0xC). The port takes word addresses. Bits [1:0] select the write operation and bits [4:2] select the register: 0 out, 1 in, 2 drive enable, 3 route, 4 interrupt enable, 5 mode, 6 sense, 7 status. Reads return the selected register whatever the operation bits hold.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, every register reads 0, `pin_oe` and `pin_out` are 0, and `irq` is low.
- R2: For the out, drive-enable, route, enable, mode and sense registers, a plain write replaces the value. A set write ORs the data in, a clear write removes the data bits, and a toggle write XORs the data in.
- R3: The in register (index 1) returns `pin_in` as sampled through two flops. A pin change is visible on the second rising clock edge after it is driven, and not before.
- R4: `pin_out` always equals the out register (index 0), and `pin_oe` always equals the drive-enable register (index 2).
- R5: Mode 0 with sense 1 (rising edge): a synchronized 0-to-1 change sets the status bit one clock after the new level reaches the in register. A 1-to-0 change does not set it, and a steady level does not re-set it after a clear.
- R6: Mode 0 with sense 0 (falling edge): a synchronized 1-to-0 change sets the status bit, and a 0-to-1 change does not.
- R7: Mode 1 with sense 1 (high level): the status bit is set on every clock while the synchronized pin is 1. It stays cleared after a clear once the pin is 0.
- R8: Mode 1 with sense 0 (low level): the status bit is set on every clock while the synchronized pin is 0.
- R9: A pin whose route bit (register 3) is 0 never sets its status bit, whatever the pin does.
- R10: Status bits latch regardless of the enable register (index 4). `irq` is high exactly when some bit is set in both status and enable.
- R11: Plain, set and toggle writes to status (index 7) have no effect, and any write to the in register (index 1) has no effect.
- R12: When a status clear and a new event for the same pin fall on the same clock, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 5 | Word address: [4:2] register, [1:0] operation |
| bus_wdata | input | NPINS | Write data / bit mask |
| bus_rdata | output | NPINS | Read data for the register at `bus_addr` |
| pin_in | input | NPINS | Asynchronous pin levels |
| pin_out | output | NPINS | Output value per pin |
| pin_oe | output | NPINS | Output driver enable per pin |
| irq | output | 1 | Combined bank interrupt |

## Verification
The hardest case to reach is a status clear that lands on the same clock as a new event for that pin. Driving it from the pins alone would need exact alignment with the synchronizer delay. The bench instead puts a pin in high-level mode and holds it high, so an event is present on every clock. A clear write then always collides with an event, and the status read right after it must still show the bit. Releasing the pin and clearing again shows that the clear itself works. The edge-mode checks sample status one clock before and one clock after the expected set point, which pins down the three-register latency.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int REG_IDX_W  = 3;
  localparam int OP_W       = 2;
  localparam int BUS_ADDR_W = REG_IDX_W + OP_W;
  localparam int NREGS      = 1 << REG_IDX_W;

  typedef enum logic [REG_IDX_W-1:0] {
    REG_OUT   = 3'd0,
    REG_IN    = 3'd1,
    REG_DRV   = 3'd2,
    REG_ROUTE = 3'd3,
    REG_IEN   = 3'd4,
    REG_MODE  = 3'd5,
    REG_SENSE = 3'd6,
    REG_STAT  = 3'd7
  } reg_e;

  typedef enum logic [OP_W-1:0] {
    OP_WRITE  = 2'd0,
    OP_SET    = 2'd1,
    OP_CLEAR  = 2'd2,
    OP_TOGGLE = 2'd3
  } op_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] q_prev
);
  logic [STAGES:0][W-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-1:0], d};
  end

  assign q      = chain_q[STAGES-1];
  assign q_prev = chain_q[STAGES];
endmodule

// File: rtl/gpio_event_detect.sv
module gpio_event_detect #(
  parameter int W = 32
) (
  input  logic [W-1:0] route,
  input  logic [W-1:0] mode_lvl,
  input  logic [W-1:0] sense_hi,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  output logic [W-1:0] hit
);
  function automatic logic pin_hit(input logic lvl, input logic hi,
                                   input logic now, input logic was);
    if (lvl) return (now == hi);
    return hi ? (now & ~was) : (~now & was);
  endfunction

  for (genvar p = 0; p < W; p++) begin : g_pin
    assign hit[p] = route[p] & pin_hit(mode_lvl[p], sense_hi[p], cur[p], prev[p]);
  end
endmodule

// File: rtl/gpio_status_reg.sv
module gpio_status_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] hit,
  output logic [W-1:0] stat_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= (stat_q & ~clr_mask) | hit;
  end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_bank_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [BUS_ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]      bus_wdata,
  output logic [NPINS-1:0]      bus_rdata,
  input  logic [NPINS-1:0]      pin_in,
  output logic [NPINS-1:0]      pin_out,
  output logic [NPINS-1:0]      pin_oe,
  output logic                  irq
);
  reg_e reg_idx;
  op_e  wr_op;
  assign reg_idx = reg_e'(bus_addr[BUS_ADDR_W-1:OP_W]);
  assign wr_op   = op_e'(bus_addr[OP_W-1:0]);

  function automatic logic [NPINS-1:0] apply_op(input op_e op,
      input logic [NPINS-1:0] old, input logic [NPINS-1:0] data);
    case (op)
      OP_SET:    return old | data;
      OP_CLEAR:  return old & ~data;
      OP_TOGGLE: return old ^ data;
      default:   return data;
    endcase
  endfunction

  function automatic logic ctrl_writable(input reg_e r);
    return (r != REG_IN) && (r != REG_STAT);
  endfunction

  logic [NREGS-1:0][NPINS-1:0] ctrl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (bus_we) begin
      for (int r = 0; r < NREGS; r++) begin
        if (reg_idx == reg_e'(r[REG_IDX_W-1:0]) && ctrl_writable(reg_idx))
          ctrl_q[r] <= apply_op(wr_op, ctrl_q[r], bus_wdata);
      end
    end
  end

  // Named internal nets for the checker
  logic [NPINS-1:0] route_w, mode_w, sense_w, ien_w;
  logic [NPINS-1:0] pin_sync, pin_prev, pin_event, stat_clr, stat_w;

  assign route_w = ctrl_q[REG_ROUTE];
  assign mode_w  = ctrl_q[REG_MODE];
  assign sense_w = ctrl_q[REG_SENSE];
  assign ien_w   = ctrl_q[REG_IEN];

  assign stat_clr = (bus_we && reg_idx == REG_STAT && wr_op == OP_CLEAR)
                    ? bus_wdata : '0;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_sync), .q_prev(pin_prev)
  );

  gpio_event_detect #(.W(NPINS)) u_detect (
    .route(route_w), .mode_lvl(mode_w), .sense_hi(sense_w),
    .cur(pin_sync), .prev(pin_prev), .hit(pin_event)
  );

  gpio_status_reg #(.W(NPINS)) u_status (
    .clk(clk), .rst_n(rst_n), .clr_mask(stat_clr), .hit(pin_event), .stat_q(stat_w)
  );

  always_comb begin
    case (reg_idx)
      REG_IN:   bus_rdata = pin_sync;
      REG_STAT: bus_rdata = stat_w;
      default:  bus_rdata = ctrl_q[reg_idx];
    endcase
  end

  assign pin_out = ctrl_q[REG_OUT];
  assign pin_oe  = ctrl_q[REG_DRV];
  assign irq     = |(stat_w & ien_w);
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NPINS-1:0] route,
  input logic [NPINS-1:0] mode_lvl,
  input logic [NPINS-1:0] sense_hi,
  input logic [NPINS-1:0] cur,
  input logic [NPINS-1:0] prev,
  input logic [NPINS-1:0] hit,
  input logic [NPINS-1:0] stat,
  input logic [NPINS-1:0] stat_clr
);
  assert_route_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit & ~route) == '0);

  assert_edge_needs_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit & ~mode_lvl & ~(cur ^ prev)) == '0);

  assert_level_matches_sense_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hit & mode_lvl & (cur ^ sense_hi)) == '0);

  assert_event_beats_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (stat & $past(hit)) == $past(hit));

  assert_status_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stat) & ~$past(stat_clr) & ~stat) == '0);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .route(route_w), .mode_lvl(mode_w),
  .sense_hi(sense_w), .cur(pin_sync), .prev(pin_prev), .hit(pin_event),
  .stat(stat_w), .stat_clr(stat_clr)
);

// File: tb/gpio_irq_bank_bench.sv
module gpio_irq_bank_bench;
  localparam int N = 32;
  localparam logic [2:0] R_OUT = 3'd0, R_IN = 3'd1, R_DRV = 3'd2, R_ROUTE = 3'd3,
                         R_IEN = 3'd4, R_MODE = 3'd5, R_SENSE = 3'd6, R_STAT = 3'd7;
  localparam logic [1:0] W_PLAIN = 2'd0, W_SET = 2'd1, W_CLR = 2'd2, W_TGL = 2'd3;

  logic clk = 1'b0, rst_n = 1'b0, bus_we = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [N-1:0] bus_wdata = '0, pin_in = '0;
  logic [N-1:0] bus_rdata, pin_out, pin_oe;
  logic irq;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_irq_bank u_gpio_irq_bank (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  task automatic check(input string tag, input logic [N-1:0] got, input logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] r, input logic [1:0] op, input logic [N-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = {r, op}; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] r, output logic [N-1:0] d);
    bus_addr = {r, W_PLAIN};
    #0.5;
    d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    for (int r = 0; r < 8; r++) begin
      rd(r[2:0], v);
      check("R1 reset register", v, '0);
    end
    check("R1 reset pin_oe", pin_oe, '0);
    check("R1 reset pin_out", pin_out, '0);
    check("R1 reset irq", {31'd0, irq}, '0);
  endtask

  task automatic t_alias();
    logic [N-1:0] v;
    wr(R_OUT, W_PLAIN, 32'hA5A5_0000); rd(R_OUT, v); check("R2 plain", v, 32'hA5A5_0000);
    wr(R_OUT, W_SET, 32'h0000_00FF);   rd(R_OUT, v); check("R2 set", v, 32'hA5A5_00FF);
    wr(R_OUT, W_CLR, 32'hA000_000F);   rd(R_OUT, v); check("R2 clear", v, 32'h05A5_00F0);
    wr(R_OUT, W_TGL, 32'hFFFF_FFFF);   rd(R_OUT, v); check("R2 toggle", v, 32'hFA5A_FF0F);
    check("R4 pin_out", pin_out, 32'hFA5A_FF0F);
    wr(R_DRV, W_PLAIN, 32'h0F0F_0F0F);
    check("R4 pin_oe", pin_oe, 32'h0F0F_0F0F);
    wr(R_DRV, W_CLR, 32'h0000_0F0F);
    check("R4 pin_oe after clear", pin_oe, 32'h0F0F_0000);
  endtask

  task automatic t_din();
    logic [N-1:0] v;
    @(negedge clk); pin_in = 32'h1234_5678;
    cyc(1); rd(R_IN, v); check("R3 not yet visible", v, '0);
    cyc(1); rd(R_IN, v); check("R3 synchronized", v, 32'h1234_5678);
    wr(R_IN, W_PLAIN, 32'hFFFF_FFFF); rd(R_IN, v); check("R11 input write ignored", v, 32'h1234_5678);
    pin_in = '0;
    cyc(4);
  endtask

  task automatic t_rise();
    logic [N-1:0] v;
    wr(R_SENSE, W_SET, 32'h1);
    wr(R_ROUTE, W_SET, 32'h1);
    @(negedge clk); pin_in[0] = 1'b1;
    cyc(2); rd(R_STAT, v); check("R5 not set early", v, '0);
    cyc(1); rd(R_STAT, v); check("R5 rising sets", v, 32'h1);
    wr(R_STAT, W_CLR, 32'h1); cyc(2); rd(R_STAT, v); check("R5 steady high no re-set", v, '0);
    pin_in[0] = 1'b0; cyc(4); rd(R_STAT, v); check("R5 falling ignored", v, '0);
  endtask

  task automatic t_fall();
    logic [N-1:0] v;
    wr(R_ROUTE, W_SET, 32'h2);
    @(negedge clk); pin_in[1] = 1'b1;
    cyc(4); rd(R_STAT, v); check("R6 rising ignored", v, '0);
    pin_in[1] = 1'b0;
    cyc(3); rd(R_STAT, v); check("R6 falling sets", v, 32'h2);
    wr(R_STAT, W_CLR, 32'h2);
  endtask

  task automatic t_high();
    logic [N-1:0] v;
    wr(R_MODE, W_SET, 32'h4);
    wr(R_SENSE, W_SET, 32'h4);
    wr(R_ROUTE, W_SET, 32'h4);
    @(negedge clk); pin_in[2] = 1'b1;
    cyc(3); rd(R_STAT, v); check("R7 high level sets", v, 32'h4);
    wr(R_STAT, W_CLR, 32'h4); rd(R_STAT, v); check("R12 event wins over clear", v, 32'h4);
    pin_in[2] = 1'b0; cyc(3);
    wr(R_STAT, W_CLR, 32'h4); cyc(2); rd(R_STAT, v); check("R7 stays clear when low", v, '0);
  endtask

  task automatic t_low();
    logic [N-1:0] v;
    wr(R_MODE, W_SET, 32'h8);
    wr(R_ROUTE, W_SET, 32'h8);
    cyc(2); rd(R_STAT, v); check("R8 low level sets", v, 32'h8);
    @(negedge clk); pin_in[3] = 1'b1; cyc(3);
    wr(R_STAT, W_CLR, 32'h8); cyc(2); rd(R_STAT, v); check("R8 clear holds when high", v, '0);
  endtask

  task automatic t_route();
    logic [N-1:0] v;
    wr(R_SENSE, W_SET, 32'h10);
    wr(R_MODE, W_SET, 32'h20);
    wr(R_SENSE, W_SET, 32'h20);
    @(negedge clk); pin_in[4] = 1'b1; pin_in[5] = 1'b1;
    cyc(4); rd(R_STAT, v); check("R9 unrouted pins silent", v, '0);
    pin_in[5] = 1'b0;
  endtask

  task automatic t_enable();
    logic [N-1:0] v;
    @(negedge clk); pin_in[0] = 1'b1;
    cyc(3); rd(R_STAT, v); check("R10 latched while disabled", v, 32'h1);
    check("R10 irq low while disabled", {31'd0, irq}, '0);
    wr(R_IEN, W_SET, 32'h40); check("R10 irq low other enable", {31'd0, irq}, '0);
    wr(R_IEN, W_SET, 32'h1);  check("R10 irq high", {31'd0, irq}, 32'h1);
    wr(R_STAT, W_CLR, 32'h1); check("R10 irq low after clear", {31'd0, irq}, '0);
  endtask

  task automatic t_statwr();
    logic [N-1:0] v;
    wr(R_STAT, W_PLAIN, 32'hFFFF_FFFF);
    wr(R_STAT, W_SET, 32'hFFFF_FFFF);
    wr(R_STAT, W_TGL, 32'hFFFF_FFFF);
    rd(R_STAT, v); check("R11 status writes ignored", v, '0);
    check("R11 irq stays low", {31'd0, irq}, '0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cyc(3);
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_alias();
    t_din();
    t_rise();
    t_fall();
    t_high();
    t_low();
    t_route();
    t_enable();
    t_statwr();
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule